// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a hardware master for the two-wire serial management bus that configures Ethernet PHYs. It produces the management clock MDC and works the bidirectional MDIO line through three signals: a data output, an output enable, and a data input. A host pulses `start_i` with an operation select, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit data word. The block then runs one complete frame on its own.

Each frame opens with a preamble of all-ones bits. A header follows, and then either a driven turnaround and write data, or a released bus on which the reply is sampled. For a read, the first bit sampled after the turnaround pulse shows whether the PHY answered. A high level there means no PHY answered: the error flag is set and the returned data is forced to zero. `busy_o` covers the whole frame and `done_o` marks its end for one clock.

The MDC period is set by a half-period divider counted in system clocks. The default of 20 gives 2.5 MHz from a 100 MHz clock. MDIO input passes through a small synchroniser before it is sampled.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever idle, `busy_o`=0, `mdc_o`=0, `mdio_oe_o`=1, `done_o`=0; after reset `rdata_o`=0 and `err_o`=0.
- R2: While a frame runs, every MDC high phase and every low phase inside the frame lasts exactly HALF_CYCLES system clocks, so successive MDC rising edges are 2*HALF_CYCLES clocks apart.
- R3: A frame starts with PREAMBLE_LEN (32) MDC pulses during which `mdio_oe_o`=1 and `mdio_o`=1.
- R4: After the preamble, 14 bits are driven MSB first: start code 01, opcode (10 read, 01 write), PHY address, register address.
- R5: `mdio_o` and `mdio_oe_o` change only in cycles where `mdc_o` is low, never in a cycle where `mdc_o` is high; the PHY sees each bit stable across the MDC rising edge.
- R6: On a write, the register address is followed by the driven pattern 10 and then the 16 data bits MSB first, with `mdio_oe_o`=1 for all 64 pulses.
- R7: On a read, `mdio_oe_o` falls after the last register-address pulse with no MDC edge in between. It stays low for the remaining 18 pulses: one turnaround pulse, one error-sample pulse and 16 data pulses.
- R8: On a read, MDIO is sampled while MDC is low, before the 48th rising edge. If it is high, `err_o`=1 and `rdata_o`=0 when the frame completes.
- R9: On a read with no error, `rdata_o` holds the 16 bits sampled before rising edges 49 to 64, MSB first. `rdata_o` and `err_o` keep the last read's result through write frames.
- R10: Each frame has exactly 64 MDC pulses. At its end `busy_o` falls, `mdc_o` stays low and `mdio_oe_o` returns to 1 with no further MDC edge.
- R11: `done_o` is high for exactly one clock per frame: the first clock with `busy_o` low after the frame.
- R12: A `start_i` pulse while `busy_o`=1 is ignored. The running frame is unchanged and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; taken only when idle |
| read_i | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock end-of-frame pulse |
| rdata_o | output | 16 | Data from the last read (zero on error) |
| err_o | output | 1 | Last read had no PHY response |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe_o | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO input |

## Verification
The assertions check the following on every cycle: idle bus levels, exact MDC high-phase length, MDIO output and enable stable whenever MDC is high, release only during a frame, the single-clock end pulse, and zero data whenever the error flag is set. Only the bench's scenarios can show frame content, because that needs a PHY model. The model records the bit and enable at each MDC rising edge and answers reads with known data or stays silent. The bench sweeps all 32 PHY addresses for both operations and adds error reads and a start request issued mid-frame. It then compares header, turnaround, write data, returned data and pulse count with values it builds itself.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int HDR_BITS = 14;
  localparam int FRAME_W  = 32;

  localparam logic [1:0] SOF_CODE  = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] TA_DRIVEN = 2'b10;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} mdc_phase_e;

  typedef struct packed {
    logic               rd;
    logic [FRAME_W-1:0] bits;
  } frame_t;

  function automatic frame_t build_frame(input logic rd,
                                         input logic [ADDR_W-1:0] phy,
                                         input logic [ADDR_W-1:0] regad,
                                         input logic [DATA_W-1:0] wd);
    frame_t f;
    f.rd   = rd;
    // read tail is never driven; fill with ones
    f.bits = rd ? {SOF_CODE, OP_READ, phy, regad, 2'b11, {DATA_W{1'b1}}}
                : {SOF_CODE, OP_WRITE, phy, regad, TA_DRIVEN, wd};
    return f;
  endfunction
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int HALF_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  frame_t frame_i,
  input  logic   tick_i,
  output logic   busy_o,
  output logic   done_o,
  output logic   mdc_o,
  output logic   mdio_o,
  output logic   mdio_oe_o,
  output logic   smp_o,
  output logic   smp_err_o,
  output logic   rd_done_o
);
  localparam int SLOTS  = PREAMBLE_LEN + FRAME_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(FRAME_W);
  localparam logic [SLOT_W-1:0] PRE_END   = SLOT_W'(PREAMBLE_LEN);
  localparam logic [SLOT_W-1:0] REL_SLOT  = SLOT_W'(PREAMBLE_LEN + HDR_BITS);
  localparam logic [SLOT_W-1:0] ERR_SLOT  = SLOT_W'(PREAMBLE_LEN + HDR_BITS + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic              busy_q, busy_d;
  mdc_phase_e        phase_q, phase_d;
  logic [SLOT_W-1:0] slot_q, slot_d, off_d;
  frame_t            frm_q, frm_d;
  logic              finish;
  logic              mdc_q, mdio_q, oe_q, done_q;
  logic              mdc_d, mdio_d, oe_d;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    slot_d  = slot_q;
    frm_d   = frm_q;
    finish  = 1'b0;
    if (start_i && !busy_q) begin
      busy_d  = 1'b1;
      phase_d = PH_LOW;
      slot_d  = '0;
      frm_d   = frame_i;
    end else if (busy_q && tick_i) begin
      if (phase_q == PH_LOW) begin
        phase_d = PH_HIGH;
      end else begin
        phase_d = PH_LOW;
        if (slot_q == LAST_SLOT) begin
          busy_d = 1'b0;
          finish = 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
    end
  end

  // outputs follow the next state so they stay aligned with it
  always_comb begin
    off_d  = slot_d - PRE_END;
    mdc_d  = busy_d && (phase_d == PH_HIGH);
    oe_d   = !(busy_d && frm_d.rd && (slot_d >= REL_SLOT));
    if (!busy_d || slot_d < PRE_END || !oe_d) mdio_d = 1'b1;
    else mdio_d = frm_d.bits[IDX_W'(FRAME_W - 1) - off_d[IDX_W-1:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= PH_LOW;
      slot_q  <= '0;
      frm_q   <= '0;
      mdc_q   <= 1'b0;
      mdio_q  <= 1'b1;
      oe_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      slot_q  <= slot_d;
      frm_q   <= frm_d;
      mdc_q   <= mdc_d;
      mdio_q  <= mdio_d;
      oe_q    <= oe_d;
      done_q  <= finish;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign mdc_o     = mdc_q;
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;
  // sample on the last clock of a low phase, before MDC rises
  assign smp_o     = busy_q && frm_q.rd && (phase_q == PH_LOW) && tick_i &&
                     (slot_q >= ERR_SLOT);
  assign smp_err_o = (slot_q == ERR_SLOT);
  assign rd_done_o = finish && frm_q.rd;
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  input  logic              smp_i,
  input  logic              smp_err_i,
  input  logic              rd_done_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  logic              din;
  logic [DATA_W-1:0] shf_q, rdata_q;
  logic              err_acc_q, err_q;

  if (SYNC_STAGES > 1) begin : g_sync
    logic [SYNC_STAGES-1:0] sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '1;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], mdio_i};
    end
    assign din = sync_q[SYNC_STAGES-1];
  end else if (SYNC_STAGES == 1) begin : g_sync1
    logic sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= 1'b1;
      else         sync_q <= mdio_i;
    end
    assign din = sync_q;
  end else begin : g_nosync
    assign din = mdio_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shf_q     <= '0;
      err_acc_q <= 1'b0;
      rdata_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      if (smp_i) begin
        if (smp_err_i) err_acc_q <= din;
        else           shf_q     <= {shf_q[DATA_W-2:0], din};
      end
      if (rd_done_i) begin
        rdata_q <= err_acc_q ? '0 : shf_q;
        err_q   <= err_acc_q;
      end
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYCLES  = 20,
  parameter int PREAMBLE_LEN = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        read_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        err_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  frame_t frame;
  logic   tick, smp, smp_err, rd_done;

  assign frame = build_frame(read_i, phy_addr_i, reg_addr_i, wdata_i);

  mdio_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  mdio_frame_seq #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .frame_i   (frame),
    .tick_i    (tick),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .smp_o     (smp),
    .smp_err_o (smp_err),
    .rd_done_o (rd_done)
  );

  mdio_rx_capture #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mdio_i    (mdio_i),
    .smp_i     (smp),
    .smp_err_i (smp_err),
    .rd_done_i (rd_done),
    .rdata_o   (rdata_o),
    .err_o     (err_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_CYCLES = 20
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o,
  input logic        err_o,
  input logic [15:0] rdata_o
);
  logic        prev_mdc;
  logic [31:0] hold_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_mdc <= 1'b0;
      hold_cnt <= '0;
    end else begin
      prev_mdc <= mdc_o;
      if (mdc_o != prev_mdc)   hold_cnt <= 32'd1;
      else if (~&hold_cnt)     hold_cnt <= hold_cnt + 32'd1;
    end
  end

  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && mdio_oe_o));

  // R2
  mdc_high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_mdc && !mdc_o) |-> (hold_cnt == 32'(HALF_CYCLES)));

  // R5
  bus_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  // R7
  release_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mdio_oe_o |-> busy_o);

  // R11
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R11
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == 16'h0000));
endmodule

bind mdio_master mdio_master_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .err_o     (err_o),
  .rdata_o   (rdata_o)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam int HALF = 2;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, read_i = 1'b0;
  logic [4:0]  phy_addr_i = '0, reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        busy_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o, mdio_i;
  logic [15:0] rdata_o;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  mdio_master #(.HALF_CYCLES(HALF)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .read_i(read_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .err_o(err_o),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  // PHY model: records the bus at each MDC rise, answers reads
  logic        clr_mon = 1'b0;
  logic        respond = 1'b1;
  logic [15:0] phy_data = '0;
  int          rises = 0;
  logic [63:0] cap_d = '0, cap_oe = '0;
  longint      cyc = 0, last_rise = 0;
  bit          per_bad = 0, hold_bad = 0;
  logic        prev_do = 1'b1, prev_oe = 1'b1;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(posedge mdc_o or posedge clr_mon) begin
    if (clr_mon) begin
      rises = 0; cap_d = '0; cap_oe = '0; per_bad = 0;
    end else begin
      if (rises > 0 && (cyc - last_rise) != 2 * HALF) per_bad = 1;
      last_rise = cyc;
      cap_d  = {cap_d[62:0], mdio_o};
      cap_oe = {cap_oe[62:0], mdio_oe_o};
      rises++;
    end
  end

  always_comb begin
    if (rises == 47)                   mdio_i = !respond;
    else if (rises >= 48 && rises <= 63) mdio_i = phy_data[63 - rises];
    else                               mdio_i = 1'b1;
  end

  always @(negedge clk_i) begin
    if (rst_ni && mdc_o && (mdio_o != prev_do || mdio_oe_o != prev_oe)) hold_bad = 1;
    prev_do = mdio_o;
    prev_oe = mdio_oe_o;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [15:0] exp_rdata = '0;
  logic        exp_err = 1'b0;

  task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input bit resp,
                           input logic [15:0] pd, input bit inject);
    logic [63:0] exp_d, exp_oe;
    int guard, extra_done;
    respond = resp; phy_data = pd;
    clr_mon = 1'b1; @(negedge clk_i); clr_mon = 1'b0;
    start_i = 1'b1; read_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
    @(negedge clk_i);
    start_i = 1'b0;
    if (inject) begin
      repeat (100) @(negedge clk_i);
      start_i = 1'b1; read_i = !rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 2000) begin @(negedge clk_i); guard++; end
    check(done_o && !busy_o, "R11", "done with busy low", {62'd0, done_o, busy_o}, 64'd2);
    if (rd) begin
      exp_err = !resp;
      exp_rdata = resp ? pd : 16'h0000;
    end
    check(err_o == exp_err, rd ? "R8" : "R9", "err flag", {63'd0, err_o}, {63'd0, exp_err});
    check(rdata_o == exp_rdata, "R9", "read data", {48'd0, rdata_o}, {48'd0, exp_rdata});
    @(negedge clk_i);
    check(!done_o, "R11", "done one clock", {63'd0, done_o}, 64'd0);
    extra_done = 0;
    repeat (20) begin @(negedge clk_i); if (done_o || busy_o) extra_done++; end
    check(extra_done == 0, "R12", "no frame after end", 64'(extra_done), 64'd0);
    check(rises == 64, "R10", "MDC pulse count", 64'(rises), 64'd64);
    check(!mdc_o && mdio_oe_o, "R10", "bus idle at end", {62'd0, mdc_o, mdio_oe_o}, 64'd1);
    check(!per_bad, "R2", "MDC period", {63'd0, per_bad}, 64'd0);
    check(cap_d[63:32] == 32'hFFFF_FFFF && cap_oe[63:32] == 32'hFFFF_FFFF, "R3",
          "preamble", cap_d, {32'hFFFF_FFFF, 32'h0});
    exp_d = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, wd};
    check(cap_d[63:18] == exp_d[63:18], "R4", "header bits", cap_d, exp_d);
    if (rd) begin
      exp_oe = {{46{1'b1}}, 18'd0};
      check(cap_oe == exp_oe, "R7", "read release pattern", cap_oe, exp_oe);
    end else begin
      check(cap_d == exp_d && cap_oe == '1, "R6", "write tail", cap_d, exp_d);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!busy_o && !mdc_o && mdio_oe_o && !done_o && rdata_o == 0 && !err_o, "R1",
          "reset state", {44'd0, busy_o, mdc_o, mdio_oe_o, done_o, rdata_o},
          {46'd0, 1'b1, 17'd0});
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 32; i++) begin
      run_frame(1'b0, 5'(i), 5'((i * 7 + 3) % 32), 16'(i * 16'h0F1D) ^ 16'h5A3C,
                1'b1, 16'h0, 1'b0);
      run_frame(1'b1, 5'(i), 5'((i * 11 + 5) % 32), 16'hFFFF, 1'b1,
                16'(i * 16'h1357 + 16'h8001), 1'b0);
    end
    // R8: silent PHY
    run_frame(1'b1, 5'd3, 5'd1, 16'h0, 1'b0, 16'hBEEF, 1'b0);
    run_frame(1'b0, 5'd4, 5'd2, 16'h1234, 1'b1, 16'h0, 1'b0);
    run_frame(1'b1, 5'd31, 5'd31, 16'h0, 1'b0, 16'hFFFF, 1'b0);
    run_frame(1'b1, 5'd0, 5'd0, 16'h0, 1'b1, 16'h0001, 1'b0);
    // R12: start requests in mid-frame
    run_frame(1'b1, 5'd9, 5'd17, 16'h0, 1'b1, 16'hC3A5, 1'b1);
    run_frame(1'b0, 5'd22, 5'd6, 16'h7E81, 1'b1, 16'h0, 1'b1);
    check(!hold_bad, "R5", "bus stable while MDC high", {63'd0, hold_bad}, 64'd0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule